// File: doc/BRIEF.md
# Programmable SPI Bit-Rate Divider

This block divides the system clock to pace a serial shift engine. A host programs a 16-bit divisor as two byte registers over a small write bus and can read either byte back. A down-counter runs from the divisor to one, reloads, and marks each reload with a single-cycle `tick_o` pulse. The pulse period is the divisor in system clock cycles. A registered clock-like output, `sck_o`, flips on every pulse, so the serial bit rate is the system clock divided by twice the divisor.

Any write to either divisor byte loads the complete new 16-bit value into the counter in the same edge. This restarts the count. Each serial role has its own lowest allowed divisor. A divisor below the minimum for the current role sets a sticky fault flag, and no pulses are produced while the flag is set. An enable input holds the counter at the divisor and stops pulses while it is low.

Top module: `spi_rate_gen`

## Requirements
- R1: After reset the divisor reads back as low byte 02h and high byte 00h. `div_bad_o` is 1 and `tick_o` and `sck_o` are 0. Because 0002h is below every minimum, no pulse appears until a legal divisor is written.
- R2: Address 0 selects the low divisor byte and address 1 selects the high byte. A write with `wr_en_i` high updates the selected byte at the clock edge. `rdata_o` shows the byte selected by `addr_i` without delay.
- R3: When `en_i` is high and the divisor D is legal, `tick_o` is high for exactly one cycle in every D cycles.
- R4: A write to either byte loads the full new divisor {high, low} into the counter at that edge. Counting the write edge as edge 0, the first pulse follows edge D and no earlier pulse occurs.
- R5: The role is set by `slave_mode_i` (0 = master, 1 = slave). The minimum divisor is 3 for master and 4 for slave. A write that leaves a divisor below the minimum for the current role sets `div_bad_o` on the next cycle, and no pulses are produced. A write that leaves a legal divisor clears `div_bad_o`.
- R6: `div_bad_o` is sticky. It also becomes set when a change of `slave_mode_i` makes the held divisor illegal. It stays set after the role changes back, until a write loads a legal divisor.
- R7: While `en_i` is low, the counter holds the divisor and no pulse occurs. When `en_i` goes high, counting the first edge with `en_i` high as edge 1, the first pulse follows edge D.
- R8: `sck_o` changes value in exactly the cycles where `tick_o` is high, and holds its value in all other cycles.
- R9: `tick_o` is never high while `div_bad_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; low holds the counter and stops pulses |
| slave_mode_i | input | 1 | Serial role: 0 master, 1 slave |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Byte select: 0 low, 1 high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Readback of the selected divisor byte |
| tick_o | output | 1 | One-cycle end-of-count pulse |
| sck_o | output | 1 | Registered output that flips on every pulse |
| div_bad_o | output | 1 | Sticky flag: divisor below the role minimum |

## Verification
The assertions check on every cycle the rules that hold locally:
- A pulse never appears while the fault flag is set.
- A pulse never lasts two cycles.
- `sck_o` moves only together with a pulse.
- No pulse directly follows a write or a cycle with enable low.

Only the bench scenarios can show the exact pulse timing: the distance from a write or an enable rise to the first pulse, the D-cycle period for several divisors, and the restart of a count partway through. The same applies to role-dependent legality, the stickiness of the flag across role changes, and the readback of both bytes.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned DIV_W      = 16;
  localparam logic [15:0] DIV_RESET  = 16'h0002;
  localparam logic [15:0] MIN_MASTER = 16'h0003;
  localparam logic [15:0] MIN_SLAVE  = 16'h0004;
endpackage

// File: rtl/spi_rate_regs.sv
module spi_rate_regs #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 2,
  parameter int unsigned ADDR_W    = 1,
  parameter logic [BYTE_W*NUM_BYTES-1:0] RESET_VAL = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [BYTE_W-1:0]             wdata_i,
  output logic [BYTE_W*NUM_BYTES-1:0]   div_o,
  output logic [BYTE_W*NUM_BYTES-1:0]   div_next_o,
  output logic                          load_o,
  output logic [BYTE_W-1:0]             rdata_o
);
  logic [NUM_BYTES-1:0] sel;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    assign sel[b] = wr_en_i && (addr_i == ADDR_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     byte_q <= RESET_VAL[b*BYTE_W +: BYTE_W];
      else if (sel[b]) byte_q <= wdata_i;
    end
    assign div_o[b*BYTE_W +: BYTE_W]      = byte_q;
    // value the counter takes on a write edge
    assign div_next_o[b*BYTE_W +: BYTE_W] = sel[b] ? wdata_i : byte_q;
  end

  assign load_o = |sel;

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (addr_i == ADDR_W'(b)) rdata_o = div_o[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/spi_rate_limit.sv
module spi_rate_limit #(
  parameter int unsigned DIV_W      = 16,
  parameter logic [DIV_W-1:0] MIN_MASTER = 3,
  parameter logic [DIV_W-1:0] MIN_SLAVE  = 4,
  parameter logic [DIV_W-1:0] RESET_DIV  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_mode_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] div_next_i,
  output logic             bad_d_o,
  output logic             bad_o
);
  localparam logic RST_BAD = (RESET_DIV < MIN_MASTER) || (RESET_DIV < MIN_SLAVE);

  logic [DIV_W-1:0] min_div;
  logic             bad_q;

  assign min_div = slave_mode_i ? MIN_SLAVE : MIN_MASTER;
  // a write re-judges the divisor; otherwise the flag only accumulates
  assign bad_d_o = load_i ? (div_next_i < min_div) : (bad_q || (div_i < min_div));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_q <= RST_BAD;
    else         bad_q <= bad_d_o;
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/spi_rate_cnt.sv
module spi_rate_cnt #(
  parameter int unsigned DIV_W = 16,
  parameter logic [DIV_W-1:0] RESET_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             block_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] div_next_i,
  output logic             tick_o,
  output logic             sck_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             end_cnt, tick_d, tick_q, sck_q;

  assign end_cnt = (cnt_q <= DIV_W'(1));
  assign tick_d  = en_i && !load_i && end_cnt && !block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= RESET_DIV;
    else if (load_i)  cnt_q <= div_next_i;
    else if (!en_i)   cnt_q <= div_i;
    else if (end_cnt) cnt_q <= div_i;
    else              cnt_q <= cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      sck_q  <= sck_q ^ tick_d;
    end
  end

  assign tick_o = tick_q;
  assign sck_o  = sck_q;
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          slave_mode_i,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic          tick_o,
  output logic          sck_o,
  output logic          div_bad_o
);
  localparam int unsigned NB = DW / BW;

  logic [DW-1:0] div, div_next;
  logic          load, bad_d;

  spi_rate_regs #(
    .BYTE_W(BW), .NUM_BYTES(NB), .ADDR_W(1), .RESET_VAL(DW'(DIV_RESET))
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .div_o(div), .div_next_o(div_next), .load_o(load),
    .rdata_o(rdata_o)
  );

  spi_rate_limit #(
    .DIV_W(DW), .MIN_MASTER(DW'(MIN_MASTER)), .MIN_SLAVE(DW'(MIN_SLAVE)),
    .RESET_DIV(DW'(DIV_RESET))
  ) u_limit (
    .clk_i(clk_i), .rst_ni(rst_ni), .slave_mode_i(slave_mode_i), .load_i(load),
    .div_i(div), .div_next_i(div_next), .bad_d_o(bad_d), .bad_o(div_bad_o)
  );

  spi_rate_cnt #(.DIV_W(DW), .RESET_DIV(DW'(DIV_RESET))) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load), .block_i(bad_d),
    .div_i(div), .div_next_i(div_next), .tick_o(tick_o), .sck_o(sck_o)
  );
endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic wr_en_i,
  input logic tick_o,
  input logic sck_o,
  input logic div_bad_o
);
  // R9
  tick_when_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> !div_bad_o);
  // R3
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R8
  sck_follows_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o != $past(sck_o)) == tick_o);
  // R4
  write_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tick_o);
  // R7
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
endmodule

bind spi_rate_gen spi_rate_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .wr_en_i(wr_en_i),
  .tick_o(tick_o), .sck_o(sck_o), .div_bad_o(div_bad_o)
);

// File: tb/spi_rate_gen_tb.sv
module spi_rate_gen_tb;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       en = 1'b0, slave = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       tick, sck, bad;

  int checks = 0, errors = 0, cyc = 0, last_e = 0;
  int exp_q[$];
  logic sck_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_rate_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .slave_mode_i(slave),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tick_o(tick), .sck_o(sck), .div_bad_o(bad)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected pulse cycles
  always @(negedge clk) begin
    if (rst_ni) begin
      if (tick) begin
        if (exp_q.size() == 0) check(1'b0, "R3 R4 unexpected tick", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R3 R4 R7 tick cycle", cyc, e);
        end
        check(sck != sck_prev, "R8 sck toggle on tick", sck, !sck_prev);
        check(!bad, "R9 tick while bad", bad, 0);
      end else if (sck != sck_prev) begin
        check(1'b0, "R8 sck moved without tick", sck, sck_prev);
      end
      sck_prev = sck;
    end
  end

  task automatic wr_byte(input logic a, input logic [7:0] d, input logic e);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; en = e;
    @(negedge clk);
    wr = 1'b0;
    last_e = cyc;
  endtask

  task automatic expect_run(input int base, input int d, input int n, input string tag);
    for (int k = 1; k <= n; k++) exp_q.push_back(base + k * d);
    while (cyc < base + n * d) @(negedge clk);
    en = 1'b0;
    repeat (d + 2) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic read_byte(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    check(bad == 1'b1, "R1 bad after reset", bad, 1);
    check(tick == 1'b0, "R1 tick after reset", tick, 0);
    check(sck == 1'b0, "R1 sck after reset", sck, 0);
    read_byte(1'b0, 8'h02, "R1 low byte reset");
    read_byte(1'b1, 8'h00, "R1 high byte reset");
    en = 1'b1;
    repeat (20) @(negedge clk);
    en = 1'b0;

    // R3 master D=3
    wr_byte(1'b0, 8'h03, 1'b1);
    check(bad == 1'b0, "R5 master D=3 legal", bad, 0);
    expect_run(last_e, 3, 4, "R3 period 3 all ticks seen");
    read_byte(1'b0, 8'h03, "R2 low byte readback");

    // R4 high then low write restarts from the low write
    wr_byte(1'b1, 8'h01, 1'b1);
    wr_byte(1'b0, 8'h05, 1'b1);
    read_byte(1'b1, 8'h01, "R2 high byte readback");
    expect_run(last_e, 261, 2, "R4 restart on low byte write");
    wr_byte(1'b1, 8'h00, 1'b0);

    // R4 restart partway through a count
    wr_byte(1'b0, 8'h0a, 1'b1);
    repeat (6) @(negedge clk);
    wr_byte(1'b0, 8'h0a, 1'b1);
    expect_run(last_e, 10, 2, "R4 mid-count restart");

    // R5 slave minimum
    slave = 1'b1;
    wr_byte(1'b0, 8'h03, 1'b1);
    check(bad == 1'b1, "R5 slave D=3 illegal", bad, 1);
    repeat (20) @(negedge clk);
    en = 1'b0;
    wr_byte(1'b0, 8'h04, 1'b1);
    check(bad == 1'b0, "R5 slave D=4 legal", bad, 0);
    expect_run(last_e, 4, 3, "R5 slave period 4");

    // R6 sticky after role change
    slave = 1'b0;
    wr_byte(1'b0, 8'h03, 1'b0);
    check(bad == 1'b0, "R6 master D=3 legal", bad, 0);
    slave = 1'b1;
    repeat (2) @(negedge clk);
    check(bad == 1'b1, "R6 role change sets bad", bad, 1);
    slave = 1'b0;
    en = 1'b1;
    repeat (12) @(negedge clk);
    check(bad == 1'b1, "R6 bad stays set", bad, 1);
    en = 1'b0;
    wr_byte(1'b0, 8'h03, 1'b1);
    check(bad == 1'b0, "R6 legal write clears", bad, 0);
    expect_run(last_e, 3, 2, "R6 ticks after clear");

    // R7 enable hold and resume
    wr_byte(1'b0, 8'h07, 1'b0);
    repeat (30) @(negedge clk);
    en = 1'b1;
    expect_run(cyc, 7, 2, "R7 resume after enable");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule